// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and gives one accept-or-drop decision per frame from the frame's 48-bit destination address. A unicast address passes only when it equals one of two programmed station addresses. A multicast address passes when its bucket in a 512-bucket hash table is marked. The broadcast address always passes. A promiscuous override passes every frame.

The bucket index is the top 9 bits of a 32-bit CRC of the address. A per-frame select picks that CRC from an input port or from an internal engine. Software marks and clears buckets one at a time through a 10-bit control word. A separate strobe empties the whole table at once. The decision comes out one clock after the frame is presented.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the verdict valid and accept outputs are low, and every hash bucket is clear.
- R2: With promisc_i high, every presented frame is accepted.
- R3: An address with bit 40 (I/G bit, LSB of the first wire byte dst_addr_i[47:40]) clear is accepted, with promisc_i low, only if it equals {sta_a_hi_i, sta_a_lo_i} or {sta_b_hi_i, sta_b_lo_i}. The hash table plays no part in this decision.
- R4: The all-ones destination address is always accepted.
- R5: An address with bit 40 set that is not all-ones is accepted, with promisc_i low, only if its hash bucket is marked.
- R6: The bucket index is bits 31:23 of the selected CRC, that is the CRC shifted right by 23. crc_int_i low selects crc_i; crc_int_i high selects the internal CRC, and crc_i is then ignored.
- R7: A hash_wr_i pulse with hash_ctrl_i[9] set marks the bucket named by hash_ctrl_i[8:0]. The same pulse with hash_ctrl_i[9] clear clears that bucket and leaves the others unchanged.
- R8: A hash_clr_i pulse clears all buckets in one cycle and takes priority over a hash_wr_i in the same cycle.
- R9: acc_vld_o is high exactly one cycle after each cycle in which frame_vld_i is high. acc_o is low whenever acc_vld_o is low.
- R10: The internal CRC is built as follows. Start from all ones. Feed the six address bytes in wire order, dst_addr_i[47:40] first, each byte LSB first. Shift right with the reflected polynomial 0xEDB88320. Apply no final inversion.
- R11: A frame presented in the same cycle as a table update is judged against the table as it stood before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| promisc_i | input | 1 | Accept all frames |
| crc_int_i | input | 1 | 1: use the internal CRC, 0: use crc_i |
| sta_a_lo_i | input | 32 | Station address A, bits 31:0 |
| sta_a_hi_i | input | 16 | Station address A, bits 47:32 |
| sta_b_lo_i | input | 32 | Station address B, bits 31:0 |
| sta_b_hi_i | input | 16 | Station address B, bits 47:32 |
| hash_wr_i | input | 1 | Strobe for a hash control write |
| hash_ctrl_i | input | 10 | [9] set/clear, [8:0] bucket index |
| hash_clr_i | input | 1 | Clear every bucket |
| frame_vld_i | input | 1 | Destination address presented this cycle |
| dst_addr_i | input | 48 | Destination address, first wire byte in [47:40] |
| crc_i | input | 32 | Externally computed CRC of the address |
| acc_vld_o | output | 1 | Verdict valid |
| acc_o | output | 1 | Frame accepted |

## Verification
The assertions assume that the station addresses and promisc_i stay stable between a frame's presentation and its verdict. They also assume that crc_i, when selected, is whatever value the requester wants hashed; no consistency with the address is expected. The stimulus changes configuration only on falling edges between frames. It drives crc_i with chosen values so that each bucket outcome is known without a CRC calculation. The internal engine is exercised separately, against a bench-side CRC model.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned HASH_W = 9;
  localparam int unsigned N_STA  = 2;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef logic [MAC_W-1:0] mac_t;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/rx_filt_crc32.sv
module rx_filt_crc32
  import rx_filt_pkg::*;
(
  input  mac_t addr_i,
  output crc_t crc_o
);
  localparam int unsigned N_BYTES = MAC_W / 8;

  crc_t c_v;
  logic fb_v;

  // wire order: top byte first, LSB of each byte first
  always_comb begin
    c_v  = '1;
    fb_v = 1'b0;
    for (int b = 0; b < N_BYTES; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb_v = c_v[0] ^ addr_i[MAC_W - 8*(b+1) + i];
        c_v  = c_v >> 1;
        if (fb_v) c_v = c_v ^ CRC_POLY;
      end
    end
    crc_o = c_v;
  end
endmodule

// File: rtl/rx_filt_hash_tbl.sv
module rx_filt_hash_tbl #(
  parameter int unsigned HASH_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              wr_i,
  input  logic              wr_set_i,
  input  logic [HASH_W-1:0] wr_idx_i,
  input  logic [HASH_W-1:0] rd_idx_i,
  output logic              rd_hit_o
);
  localparam int unsigned N_BKT = 1 << HASH_W;

  logic [N_BKT-1:0] bkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bkt_q <= '0;
    else if (clr_all_i) bkt_q <= '0;
    else if (wr_i)      bkt_q[wr_idx_i] <= wr_set_i;
  end

  // read sees the pre-update table
  assign rd_hit_o = bkt_q[rd_idx_i];

  p_clear_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (bkt_q == '0));

  p_bucket_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_all_i) |=> (bkt_q[$past(wr_idx_i)] == $past(wr_set_i)));

  p_one_bucket_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_all_i) |=> ($countones(bkt_q ^ $past(bkt_q)) <= 1));
endmodule

// File: rtl/rx_filt_sta_match.sv
module rx_filt_sta_match
  import rx_filt_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  mac_t         addr_i,
  input  mac_t [N-1:0] sta_i,
  output logic         hit_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_sta
    assign hit[g] = (addr_i == sta_i[g]);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int unsigned HASH_BITS = rx_filt_pkg::HASH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 promisc_i,
  input  logic                 crc_int_i,
  input  logic [31:0]          sta_a_lo_i,
  input  logic [15:0]          sta_a_hi_i,
  input  logic [31:0]          sta_b_lo_i,
  input  logic [15:0]          sta_b_hi_i,
  input  logic                 hash_wr_i,
  input  logic [HASH_BITS:0]   hash_ctrl_i,
  input  logic                 hash_clr_i,
  input  logic                 frame_vld_i,
  input  logic [MAC_W-1:0]     dst_addr_i,
  input  logic [CRC_W-1:0]     crc_i,
  output logic                 acc_vld_o,
  output logic                 acc_o
);
  localparam int unsigned IG_BIT = MAC_W - 8;

  mac_t [N_STA-1:0] sta;
  crc_t crc_calc, crc_sel;
  logic [HASH_BITS-1:0] bkt_idx;
  logic is_mc, is_bc, sta_hit, hash_hit, accept;
  logic acc_vld_q, acc_q;

  assign sta[0] = {sta_a_hi_i, sta_a_lo_i};
  assign sta[1] = {sta_b_hi_i, sta_b_lo_i};

  rx_filt_crc32 i_crc (
    .addr_i (dst_addr_i),
    .crc_o  (crc_calc)
  );

  assign crc_sel = crc_int_i ? crc_calc : crc_i;
  assign bkt_idx = crc_sel[CRC_W-1 -: HASH_BITS];

  rx_filt_hash_tbl #(.HASH_W(HASH_BITS)) i_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (hash_clr_i),
    .wr_i      (hash_wr_i),
    .wr_set_i  (hash_ctrl_i[HASH_BITS]),
    .wr_idx_i  (hash_ctrl_i[HASH_BITS-1:0]),
    .rd_idx_i  (bkt_idx),
    .rd_hit_o  (hash_hit)
  );

  rx_filt_sta_match #(.N(N_STA)) i_sta (
    .addr_i (dst_addr_i),
    .sta_i  (sta),
    .hit_o  (sta_hit)
  );

  assign is_mc  = dst_addr_i[IG_BIT];
  assign is_bc  = &dst_addr_i;
  assign accept = promisc_i | is_bc | (is_mc ? hash_hit : sta_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_vld_q <= 1'b0;
      acc_q     <= 1'b0;
    end else begin
      acc_vld_q <= frame_vld_i;
      acc_q     <= frame_vld_i & accept;
    end
  end

  assign acc_vld_o = acc_vld_q;
  assign acc_o     = acc_q;

  p_verdict_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> acc_vld_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> (!acc_vld_o && !acc_o));

  p_promisc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && promisc_i) |=> acc_o);

  p_bcast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (&dst_addr_i)) |=> acc_o);

  p_uni_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !promisc_i && !dst_addr_i[IG_BIT] &&
     dst_addr_i != {sta_a_hi_i, sta_a_lo_i} &&
     dst_addr_i != {sta_b_hi_i, sta_b_lo_i}) |=> !acc_o);
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  typedef struct packed {
    logic        promisc;
    logic [31:0] crc;
    logic [47:0] da;
    logic        exp;
  } vec_t;

  localparam logic [47:0] STA_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] STA_B = 48'h0A_BC_DE_F0_12_34;
  localparam logic [47:0] MC_A  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC_B  = 48'h33_33_00_00_00_FB;
  localparam int N_VEC = 10;

  // buckets 0x05A and 0x1FF are marked before the walk
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 32'h0000_0000, STA_A,                 1'b1},
    '{1'b0, 32'h0000_0000, STA_B,                 1'b1},
    '{1'b0, 32'h0000_0000, 48'h02_11_22_33_44_56, 1'b0},
    '{1'b1, 32'h0000_0000, 48'h02_11_22_33_44_56, 1'b1},
    '{1'b0, 32'h0000_0000, 48'hFF_FF_FF_FF_FF_FF, 1'b1},
    '{1'b0, {9'h05A, 23'h0},       MC_A,          1'b1},
    '{1'b0, {9'h05B, 23'h7F_FFFF}, MC_A,          1'b0},
    '{1'b0, {9'h1FF, 23'h0},       MC_B,          1'b1},
    '{1'b1, {9'h000, 23'h0},       MC_B,          1'b1},
    '{1'b0, {9'h05A, 23'h0}, 48'h02_00_00_00_00_01, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic promisc, crc_int, hash_wr, hash_clr, frame_vld;
  logic [9:0]  hash_ctrl;
  logic [47:0] dst_addr;
  logic [31:0] crc_ext;
  logic acc_vld, acc;
  int n_chk = 0;
  int n_fail = 0;
  logic v, a;

  always #4 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk_i(clk), .rst_ni(rst_ni), .promisc_i(promisc), .crc_int_i(crc_int),
    .sta_a_lo_i(STA_A[31:0]), .sta_a_hi_i(STA_A[47:32]),
    .sta_b_lo_i(STA_B[31:0]), .sta_b_hi_i(STA_B[47:32]),
    .hash_wr_i(hash_wr), .hash_ctrl_i(hash_ctrl), .hash_clr_i(hash_clr),
    .frame_vld_i(frame_vld), .dst_addr_i(dst_addr), .crc_i(crc_ext),
    .acc_vld_o(acc_vld), .acc_o(acc)
  );

  function automatic logic [8:0] ref_bucket(input logic [47:0] da);
    logic [31:0] c = '1;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ da[40 - 8*b + i];
        c = c >> 1;
        if (fb) c ^= 32'hEDB88320;
      end
    return c[31:23];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic pm, input logic ci, input logic [31:0] c,
                      input logic [47:0] da, output logic vo, output logic ao);
    @(negedge clk);
    promisc = pm; crc_int = ci; crc_ext = c; dst_addr = da; frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    vo = acc_vld; ao = acc;
  endtask

  task automatic hwrite(input logic set, input logic [8:0] idx);
    @(negedge clk);
    hash_wr = 1'b1; hash_ctrl = {set, idx};
    @(negedge clk);
    hash_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    promisc = 0; crc_int = 0; hash_wr = 0; hash_clr = 0; frame_vld = 0;
    hash_ctrl = '0; dst_addr = '0; crc_ext = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(acc_vld, 1'b0, "R1 valid low in reset");
    check(acc, 1'b0, "R1 accept low in reset");
    rst_ni = 1'b1;
    send(0, 0, {9'h05A, 23'h0}, MC_A, v, a);
    check(a, 1'b0, "R1 table empty after reset");
    // R9 idle cycle gives no verdict
    @(negedge clk);
    check(acc_vld, 1'b0, "R9 no verdict without frame");

    hwrite(1'b1, 9'h05A);
    hwrite(1'b1, 9'h1FF);
    for (int k = 0; k < N_VEC; k++) begin
      send(VECS[k].promisc, 1'b0, VECS[k].crc, VECS[k].da, v, a);
      check(v, 1'b1, "R9 verdict valid");
      check(a, VECS[k].exp, "R2 R3 R4 R5 R6 vector");
    end

    // R7 clear one bucket, neighbour stays set
    hwrite(1'b0, 9'h05A);
    send(0, 0, {9'h05A, 23'h0}, MC_A, v, a);
    check(a, 1'b0, "R7 cleared bucket rejects");
    send(0, 0, {9'h1FF, 23'h0}, MC_A, v, a);
    check(a, 1'b1, "R7 other bucket kept");

    // R10 / R6 internal CRC; crc_i points at a marked bucket but is ignored
    hwrite(1'b1, ref_bucket(MC_A));
    send(0, 1, {9'h1FF, 23'h0}, MC_A, v, a);
    check(a, 1'b1, "R10 internal crc hit");
    hwrite(1'b0, ref_bucket(MC_A));
    send(0, 1, {9'h1FF, 23'h0}, MC_A, v, a);
    check(a, 1'b0, "R6 crc_i ignored in internal mode");

    // R11 frame and write in the same cycle
    @(negedge clk);
    hash_wr = 1'b1; hash_ctrl = {1'b1, 9'h0C3};
    promisc = 0; crc_int = 0; crc_ext = {9'h0C3, 23'h0}; dst_addr = MC_B; frame_vld = 1'b1;
    @(negedge clk);
    hash_wr = 1'b0; frame_vld = 1'b0;
    check(acc, 1'b0, "R11 same-cycle write not seen");
    send(0, 0, {9'h0C3, 23'h0}, MC_B, v, a);
    check(a, 1'b1, "R11 write seen next frame");

    // R8 clear-all wins over a concurrent write
    @(negedge clk);
    hash_clr = 1'b1; hash_wr = 1'b1; hash_ctrl = {1'b1, 9'h010};
    @(negedge clk);
    hash_clr = 1'b0; hash_wr = 1'b0;
    send(0, 0, {9'h1FF, 23'h0}, MC_B, v, a);
    check(a, 1'b0, "R8 table cleared");
    send(0, 0, {9'h010, 23'h0}, MC_B, v, a);
    check(a, 1'b0, "R8 clear beats write");
    send(0, 0, 32'h0, 48'hFF_FF_FF_FF_FF_FF, v, a);
    check(a, 1'b1, "R4 broadcast with empty table");

    finish_run();
  end
endmodule